// File: doc/BRIEF.md
# Microcoded Accumulator Processor Controller

This block is a small 8-bit accumulator machine. A non-pipelined microsequencer runs its control, and each microword in the control store has three parts: a set of datapath action enables, a sequencing mode, and up to two target microaddresses. The machine has these registers:

- an instruction register
- an instruction pointer
- an accumulator
- a memory-data operand register
- a saved-return register
- a zero flag

The instruction is read from memory at the pointer, and the pointer is advanced in the same microword. The sequencer then jumps to one of sixteen routine entries, chosen by the upper nibble of the fetched byte. Short routines implement four instructions: add, subroutine call, return and branch-if-zero. Every other opcode runs a do-nothing microword.

Memory is read through an address output, a read strobe and a read-data input. The read-data input must carry the addressed byte in the same cycle as the strobe.

The operand register is loaded through a valid/ready write port. Ready is held high, so the port never back-pressures, and a byte is accepted on every clock edge where valid is high.

The current microaddress is brought out so that the executed microword sequence can be traced. The pointer, accumulator and zero flag are also brought out.

Top module: `ucode_acc_cpu`

## Requirements
- R1: While reset is low, and on release: microaddress 0 (fetch), pointer 0, accumulator 0, operand register 0, saved-return register 0, and zero flag 1.
- R2: The fetch microword (microaddress 0) loads the instruction register from memory at the pointer and increments the pointer. The next microaddress comes from the fetched byte's bits [7:4]: opcode 1 gives 1 (add), 2 gives 2 (call), 3 gives 4 (return), 4 gives 5 (branch-if-zero), and every other opcode gives 7.
- R3: Add is one microword (microaddress 1). It sets accumulator = (accumulator + operand) mod 256, sets the zero flag to whether that result is 0, and then goes to fetch.
- R4: Call is two microwords. The first (microaddress 2) reads the address byte at the pointer without advancing the pointer, and saves pointer + 1 as the return address. The second (microaddress 3) copies that byte into the pointer. Control then goes to fetch.
- R5: Return is one microword (microaddress 4). It copies the saved-return register into the pointer and goes to fetch.
- R6: Branch-if-zero with the zero flag at 0 runs one microword (microaddress 5). It reads the address byte, advances the pointer past it, and goes to fetch.
- R7: Branch-if-zero with the zero flag at 1 runs microaddress 5 and then microaddress 6. Microaddress 6 loads the pointer with the address byte before going to fetch.
- R8: The do-nothing microword (microaddress 7) changes neither the accumulator, the zero flag nor the pointer, and goes to fetch.
- R9: `md_ready` is always 1. An operand byte with `md_valid` high is stored at that clock edge. An add executing in that same cycle uses the previous operand value.
- R10: `mem_rd` is high exactly in microwords 0, 2 and 5, and while it is high `mem_addr` equals the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Memory address (the pointer) |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Byte read from memory, valid in the strobe cycle |
| md_valid | input | 1 | Operand write valid |
| md_ready | output | 1 | Operand write ready (always 1) |
| md_data | input | 8 | Operand write data |
| uaddr | output | 4 | Current microaddress |
| ip_o | output | 8 | Instruction pointer |
| acc_o | output | 8 | Accumulator |
| zero_o | output | 1 | Zero flag |

## Verification
An operand write and the add microword can land in the same cycle, because the write port is free-running while the add reads the operand register. The bench provokes this by holding `md_valid` high with a new byte during the add's microword. It then judges the result twice: the accumulator must reflect the old operand, and the following add must reflect the new one. Every instruction's microaddress trace is compared cycle by cycle against the sequence its requirement lists. Both branch-if-zero outcomes are reached by driving the accumulator to exactly zero through 8-bit wraparound.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int UAW = 4;
  localparam int OPW = 4;

  localparam logic [UAW-1:0] UA_FETCH = 4'd0;
  localparam logic [UAW-1:0] UA_ADD   = 4'd1;
  localparam logic [UAW-1:0] UA_CALL0 = 4'd2;
  localparam logic [UAW-1:0] UA_CALL1 = 4'd3;
  localparam logic [UAW-1:0] UA_RET   = 4'd4;
  localparam logic [UAW-1:0] UA_BRZ0  = 4'd5;
  localparam logic [UAW-1:0] UA_BRZ1  = 4'd6;
  localparam logic [UAW-1:0] UA_NOP   = 4'd7;

  localparam logic [OPW-1:0] OP_ADD  = 4'h1;
  localparam logic [OPW-1:0] OP_CALL = 4'h2;
  localparam logic [OPW-1:0] OP_RET  = 4'h3;
  localparam logic [OPW-1:0] OP_BRZ  = 4'h4;

  typedef enum logic [1:0] {
    SEQ_GOTO     = 2'd0,
    SEQ_DISPATCH = 2'd1,
    SEQ_COND_Z   = 2'd2
  } seq_e;

  typedef struct packed {
    logic ir_ld;   // IR <- M[IP], drives the read strobe
    logic ip_inc;  // IP <- IP + 1
    logic ip_ir;   // IP <- IR
    logic ip_sr;   // IP <- SR
    logic ac_add;  // AC <- AC + MD, Z updated
    logic sr_ld;   // SR <- IP + 1
  } act_t;

  typedef struct packed {
    act_t           act;
    seq_e           seq;
    logic [UAW-1:0] t_false;
    logic [UAW-1:0] t_true;
  } uword_t;
endpackage

// File: rtl/acc_dispatch.sv
module acc_dispatch
  import acc_pkg::*;
(
  input  logic [OPW-1:0] op,
  output logic [UAW-1:0] entry
);
  localparam int NOPC = 2 ** OPW;

  function automatic logic [UAW-1:0] entry_of(input logic [OPW-1:0] o);
    case (o)
      OP_ADD:  return UA_ADD;
      OP_CALL: return UA_CALL0;
      OP_RET:  return UA_RET;
      OP_BRZ:  return UA_BRZ0;
      default: return UA_NOP;
    endcase
  endfunction

  logic [UAW-1:0] tbl [NOPC];

  for (genvar g = 0; g < NOPC; g++) begin : g_tbl
    assign tbl[g] = entry_of(OPW'(g));
  end

  assign entry = tbl[op];
endmodule

// File: rtl/acc_ustore.sv
module acc_ustore
  import acc_pkg::*;
(
  input  logic [UAW-1:0] ua,
  output uword_t         uw
);
  always_comb begin
    uw.act     = '{ir_ld: 1'b0, ip_inc: 1'b0, ip_ir: 1'b0,
                   ip_sr: 1'b0, ac_add: 1'b0, sr_ld: 1'b0};
    uw.seq     = SEQ_GOTO;
    uw.t_false = UA_FETCH;
    uw.t_true  = UA_FETCH;
    case (ua)
      UA_FETCH: begin
        uw.act.ir_ld  = 1'b1;
        uw.act.ip_inc = 1'b1;
        uw.seq        = SEQ_DISPATCH;
      end
      UA_ADD: uw.act.ac_add = 1'b1;
      UA_CALL0: begin
        uw.act.ir_ld = 1'b1;
        uw.act.sr_ld = 1'b1;
        uw.t_false   = UA_CALL1;
      end
      UA_CALL1: uw.act.ip_ir = 1'b1;
      UA_RET:   uw.act.ip_sr = 1'b1;
      UA_BRZ0: begin
        uw.act.ir_ld  = 1'b1;
        uw.act.ip_inc = 1'b1;
        uw.seq        = SEQ_COND_Z;
        uw.t_true     = UA_BRZ1;
        uw.t_false    = UA_FETCH;
      end
      UA_BRZ1: uw.act.ip_ir = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_useq.sv
module acc_useq
  import acc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  uword_t         uw,
  input  logic [UAW-1:0] dispatch_ua,
  input  logic           cond_z,
  output logic [UAW-1:0] ua
);
  logic [UAW-1:0] ua_next;

  always_comb begin
    case (uw.seq)
      SEQ_DISPATCH: ua_next = dispatch_ua;
      SEQ_COND_Z:   ua_next = cond_z ? uw.t_true : uw.t_false;
      default:      ua_next = uw.t_false;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ua <= UA_FETCH;
    else        ua <= ua_next;
  end
endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  act_t           act,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           md_valid,
  input  logic [DW-1:0]  md_data,
  output logic [DW-1:0]  mem_addr,
  output logic [OPW-1:0] op_next,
  output logic [DW-1:0]  ip_q,
  output logic [DW-1:0]  ac_q,
  output logic [DW-1:0]  sr_q,
  output logic           z_q
);
  logic [DW-1:0] ir_q;
  logic [DW-1:0] md_q;
  logic [DW-1:0] sum;
  logic [DW-1:0] ip_plus1;

  assign sum      = ac_q + md_q;
  assign ip_plus1 = ip_q + DW'(1);
  assign mem_addr = ip_q;
  assign op_next  = act.ir_ld ? mem_rdata[DW-1 -: OPW] : ir_q[DW-1 -: OPW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q <= '0;
      ip_q <= '0;
      ac_q <= '0;
      md_q <= '0;
      sr_q <= '0;
      z_q  <= 1'b1;
    end else begin
      if (act.ir_ld) ir_q <= mem_rdata;
      if (act.ip_ir)       ip_q <= ir_q;
      else if (act.ip_sr)  ip_q <= sr_q;
      else if (act.ip_inc) ip_q <= ip_plus1;
      if (act.sr_ld) sr_q <= ip_plus1;
      if (act.ac_add) begin
        ac_q <= sum;
        z_q  <= (sum == '0);
      end
      if (md_valid) md_q <= md_data;
    end
  end
endmodule

// File: rtl/ucode_acc_cpu.sv
module ucode_acc_cpu
  import acc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [DW-1:0]  mem_addr,
  output logic           mem_rd,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           md_valid,
  output logic           md_ready,
  input  logic [DW-1:0]  md_data,
  output logic [UAW-1:0] uaddr,
  output logic [DW-1:0]  ip_o,
  output logic [DW-1:0]  acc_o,
  output logic           zero_o
);
  uword_t         uw;
  logic [OPW-1:0] op_next;
  logic [UAW-1:0] disp_ua;
  logic [DW-1:0]  sr_w;

  acc_ustore u_store (.ua(uaddr), .uw(uw));

  acc_dispatch u_disp (.op(op_next), .entry(disp_ua));

  acc_useq u_seq (
    .clk(clk), .rst_n(rst_n), .uw(uw), .dispatch_ua(disp_ua),
    .cond_z(zero_o), .ua(uaddr)
  );

  acc_dpath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .act(uw.act), .mem_rdata(mem_rdata),
    .md_valid(md_valid), .md_data(md_data), .mem_addr(mem_addr),
    .op_next(op_next), .ip_q(ip_o), .ac_q(acc_o), .sr_q(sr_w), .z_q(zero_o)
  );

  assign mem_rd   = uw.act.ir_ld;
  assign md_ready = 1'b1;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_pkg::*;
#(
  parameter int DW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [UAW-1:0] ua,
  input logic           mem_rd,
  input logic [DW-1:0]  mem_addr,
  input logic [DW-1:0]  ip,
  input logic [DW-1:0]  ac,
  input logic [DW-1:0]  sr,
  input logic           z
);
  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (ua == UA_FETCH && ip == '0 && ac == '0 && z));

  p_fetch_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == UA_FETCH) |=> (ip == DW'($past(ip) + DW'(1))));

  p_add_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == UA_ADD) |=> (ua == UA_FETCH));

  p_zero_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    z == (ac == '0));

  p_call_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == UA_CALL0) |=> (ua == UA_CALL1 && ip == $past(ip)
                          && sr == DW'($past(ip) + DW'(1))));

  p_ret_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == UA_RET) |=> (ip == $past(sr) && ua == UA_FETCH));

  p_brz_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == UA_BRZ0 && !z) |=> (ua == UA_FETCH));

  p_brz_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == UA_BRZ0 && z) |=> (ua == UA_BRZ1));

  p_nop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == UA_NOP) |=> ($stable(ac) && $stable(ip) && $stable(z)
                        && ua == UA_FETCH));

  p_read_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr == ip
                && (ua == UA_FETCH || ua == UA_CALL0 || ua == UA_BRZ0)));
endmodule

bind ucode_acc_cpu acc_cpu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ua(uaddr), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .ip(ip_o), .ac(acc_o), .sr(sr_w), .z(zero_o)
);

// File: tb/ucode_acc_cpu_tb.sv
module ucode_acc_cpu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr;
  logic       mem_rd;
  logic [7:0] mem_rdata;
  logic       md_valid = 1'b0;
  logic       md_ready;
  logic [7:0] md_data = 8'h00;
  logic [3:0] uaddr;
  logic [7:0] ip_o;
  logic [7:0] acc_o;
  logic       zero_o;

  logic [7:0] mem [0:255];
  assign mem_rdata = mem[mem_addr];

  always #10 clk = ~clk;

  ucode_acc_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .md_valid(md_valid), .md_ready(md_ready),
    .md_data(md_data), .uaddr(uaddr), .ip_o(ip_o), .acc_o(acc_o),
    .zero_o(zero_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [7:0] m_ac = 8'h00, m_md = 8'h00, m_sr = 8'h00;
  logic       m_z = 1'b1;

  // {instruction, address byte, operand}
  localparam logic [23:0] VEC [13] = '{
    24'h10_00_05, 24'h40_80_00, 24'h20_30_00, 24'h70_00_00,
    24'h30_00_00, 24'h10_00_FB, 24'h40_90_00, 24'hF5_00_00,
    24'h10_00_00, 24'h10_00_80, 24'h10_00_80, 24'h00_00_00,
    24'h40_05_00
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op, input logic z);
    case (op)
      4'h1: return "R3";
      4'h2: return "R4";
      4'h3: return "R5";
      4'h4: return z ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  // Called at a negedge with uaddr at fetch.
  task automatic run_instr(input logic [7:0] ins, input logic [7:0] adr,
                           input logic [7:0] md, input bit ld_md);
    logic [7:0] ip0;
    logic [3:0] op;
    logic [3:0] tr [2];
    int         nt;
    logic [7:0] e_ip;
    string      rq;
    ip0 = ip_o;
    op  = ins[7:4];
    rq  = req_of(op, m_z);
    mem[ip0] = ins;
    mem[8'(ip0 + 8'd1)] = adr;
    if (ld_md) begin
      md_valid = 1'b1;
      md_data  = md;
    end
    chk(uaddr == 4'd0 && mem_rd && mem_addr == ip0, "R10", {uaddr, mem_addr}, {4'd0, ip0});
    nt = 1;
    tr[1] = 4'd0;
    e_ip = 8'(ip0 + 8'd1);
    case (op)
      4'h1: tr[0] = 4'd1;
      4'h2: begin tr[0] = 4'd2; tr[1] = 4'd3; nt = 2; end
      4'h3: tr[0] = 4'd4;
      4'h4: begin tr[0] = 4'd5; if (m_z) begin tr[1] = 4'd6; nt = 2; end end
      default: tr[0] = 4'd7;
    endcase
    @(negedge clk);
    if (ld_md) begin
      md_valid = 1'b0;
      m_md = md;
    end
    chk(uaddr == tr[0], "R2", uaddr, tr[0]);
    if (tr[0] == 4'd2 || tr[0] == 4'd5)
      chk(mem_rd && mem_addr == e_ip, "R10", mem_addr, e_ip);
    else
      chk(!mem_rd, "R10", mem_rd, 0);
    for (int k = 1; k < nt; k++) begin
      @(negedge clk);
      chk(uaddr == tr[k], rq, uaddr, tr[k]);
    end
    @(negedge clk);
    chk(uaddr == 4'd0, rq, uaddr, 0);
    case (op)
      4'h1: begin m_ac = m_ac + m_md; m_z = (m_ac == 8'h00); end
      4'h2: begin m_sr = 8'(ip0 + 8'd2); e_ip = adr; end
      4'h3: e_ip = m_sr;
      4'h4: e_ip = m_z ? adr : 8'(ip0 + 8'd2);
      default: ;
    endcase
    chk(ip_o == e_ip, rq, ip_o, e_ip);
    chk(acc_o == m_ac && zero_o == m_z, rq, {acc_o, 3'b0, zero_o}, {m_ac, 3'b0, m_z});
  endtask

  initial begin
    logic [7:0] ipx;
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(uaddr == 4'd0, "R1", uaddr, 0);
    chk(ip_o == 8'h00 && acc_o == 8'h00 && zero_o, "R1", {ip_o, acc_o}, 0);
    chk(md_ready, "R9", md_ready, 1);
    rst_n = 1'b1;

    for (int v = 0; v < 13; v++)
      run_instr(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 1'b1);

    // R9: operand write during the add microword; add uses the old operand
    ipx = ip_o;
    mem[ipx] = 8'h10;
    md_valid = 1'b1;
    md_data  = 8'h03;
    @(negedge clk);
    chk(uaddr == 4'd1, "R9", uaddr, 1);
    md_data = 8'h40;
    @(negedge clk);
    md_valid = 1'b0;
    m_ac = m_ac + 8'h03;
    m_z  = (m_ac == 8'h00);
    m_md = 8'h40;
    chk(acc_o == m_ac, "R9", acc_o, m_ac);
    chk(md_ready, "R9", md_ready, 1);
    run_instr(8'h10, 8'h00, 8'h00, 1'b0);
    chk(acc_o == m_ac, "R9", acc_o, m_ac);

    // R1: reset in the middle of a call
    ipx = ip_o;
    mem[ipx] = 8'h20;
    mem[8'(ipx + 8'd1)] = 8'h66;
    @(negedge clk);
    chk(uaddr == 4'd2, "R4", uaddr, 2);
    rst_n = 1'b0;
    @(negedge clk);
    chk(uaddr == 4'd0 && ip_o == 8'h00, "R1", {uaddr, ip_o}, 0);
    chk(acc_o == 8'h00 && zero_o, "R1", {acc_o, zero_o}, 1);
    rst_n = 1'b1;
    m_ac = 8'h00; m_md = 8'h00; m_sr = 8'h00; m_z = 1'b1;
    run_instr(8'h10, 8'h00, 8'h00, 1'b0);   // R1: operand cleared
    run_instr(8'h30, 8'h00, 8'h00, 1'b0);   // R1: return register cleared

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule